// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This block decides, on a one-cycle evaluate strobe, whether the interrupt level offered by the pending-interrupt logic may be taken. If it may, the block computes every piece of processor state that changes as a result. It checks the offered level against the interrupt-level field of the status word and against the number of configured levels. It also requires at least one line that belongs to that level to be both raised and enabled.

A level above 1 goes down the banked path. The block stores the interrupted PC and status word into the registers for that level, raises the status level to the taken level, sets exception mode and redirects fetch to that level's vector. Level 1 goes down the general-exception path instead. It writes the level-1 interrupt cause code and sets exception mode. It routes to a user, kernel or double-exception vector depending on the exception-mode and user-mode bits that were in force when the interrupt arrived.

All results are registered and appear one cycle after the evaluate strobe. A taken pulse accompanies them, along with write enables that tell the surrounding special-register file which saved-state registers to load. Vector addresses may be relocated through a vector-base input.

Top module: `irq_dispatch`

## Requirements
- R1: An evaluation is taken only when the offered level is above status bits [3:0], is no more than NLEVEL (default 6), and (level mask AND raised lines AND enabled lines) is nonzero. Interrupt line i belongs to level (i mod NLEVEL)+1. A level of 0, an out-of-range level, an equal or lower level, or a request with no qualifying line produces no taken pulse and no write enable, and leaves the redirect PC and new-status outputs unchanged.
- R2: A taken level L>1 asserts both the PC-save and status-save write enables with save_lvl_o = L, save_pc_o equal to the interrupted PC and save_ps_o equal to the interrupted status word. It does not write the cause.
- R3: A taken level L>1 yields a new status word whose bits [3:0] equal L, whose exception-mode bit (default bit 4) is set, and whose other bits are copied from the interrupted status word.
- R4: A taken level L>1 redirects to vector base + HI_OFS0 + (L-2)*HI_STRIDE (defaults 0x180 and 0x40), with route_o = 0.
- R5: A taken level 1 asserts the cause write enable with cause_o = CAUSE_L1 (default 4). The new status word is the old one with the exception-mode bit set, and save_lvl_o = 1.
- R6: A taken level 1 with the exception-mode bit already set is a double exception: route_o = 3 and the target is vector base + DBL_OFS (default 0x3C0). The PC goes to the double-exception PC register (depc_we_o) when HAS_DEPC is nonzero, and to the level-1 PC register otherwise.
- R7: A taken level 1 with the exception-mode bit clear loads the level-1 PC register (epc_we_o, save_lvl_o = 1). If the user-mode bit (default bit 5) is set it targets vector base + USER_OFS (0x340) with route_o = 2, otherwise vector base + KERN_OFS (0x300) with route_o = 1.
- R8: With RELOC_EN set, the vector base is vecbase_i, meaning the default vector minus DEF_VECBASE plus the relocation register. With RELOC_EN clear it is DEF_VECBASE.
- R9: taken_o is high for exactly the cycle after each qualifying evaluation, and no write enable is ever high without it.
- R10: After reset, taken_o and all write enables are low and every data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | Evaluate the offered level this cycle |
| pend_level_i | input | 4 | Highest pending interrupt level |
| ps_i | input | 32 | Current status word |
| pc_i | input | 32 | PC of the interrupted instruction |
| intset_i | input | 32 | Raised interrupt lines |
| intenable_i | input | 32 | Enabled interrupt lines |
| vecbase_i | input | 32 | Vector relocation base |
| taken_o | output | 1 | One-cycle taken pulse |
| pc_o | output | 32 | Redirect target |
| ps_o | output | 32 | New status word |
| save_pc_o | output | 32 | PC value to store |
| save_ps_o | output | 32 | Status value to store |
| save_lvl_o | output | 4 | Bank index for the stores |
| route_o | output | 2 | 0 banked level, 1 kernel, 2 user, 3 double |
| epc_we_o | output | 1 | Load level PC register |
| eps_we_o | output | 1 | Load level status register |
| depc_we_o | output | 1 | Load double-exception PC register |
| cause_we_o | output | 1 | Load cause register |
| cause_o | output | 32 | Cause value |

## Verification
A level-1 interrupt that arrives while exception mode is already set exercises two functions in one dispatch: the cause write and the double-exception routing. The bench provokes this by offering level 1 with the exception-mode bit set, and checks that the cause code, the double vector and the choice of PC register all appear in the same result cycle. A qualifying evaluation followed immediately by a non-qualifying one makes the falling taken pulse coincide with the hold of the previous redirect target. The scoreboard judges that cycle against the last expected target.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    typedef enum logic [1:0] {
        ROUTE_HIGH = 2'd0,
        ROUTE_KERN = 2'd1,
        ROUTE_USER = 2'd2,
        ROUTE_DBL  = 2'd3
    } route_e;

    typedef struct packed {
        logic        taken;
        logic [31:0] pc;
        logic [31:0] ps;
        logic [31:0] spc;
        logic [31:0] sps;
        logic [3:0]  lvl;
        route_e      route;
        logic        epc_we;
        logic        eps_we;
        logic        depc_we;
        logic        cause_we;
        logic [31:0] cause;
    } disp_s;

    // Line i belongs to level (i mod nlevel) + 1.
    function automatic logic [31:0] lvl_mask(input int lvl, input int nlevel);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if ((i % nlevel) + 1 == lvl) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irqd_qual.sv
module irqd_qual #(
    parameter int NLEVEL = 6
) (
    input  logic [3:0]  pend_level_i,
    input  logic [3:0]  cur_level_i,
    input  logic [31:0] intset_i,
    input  logic [31:0] intenable_i,
    output logic        hit_o
);
    logic [31:0] live;
    logic [NLEVEL:1] lvl_hit;
    logic sel;
    logic in_range;

    assign live = intset_i & intenable_i;

    for (genvar l = 1; l <= NLEVEL; l++) begin : g_lvl
        localparam logic [31:0] MASK = irqd_pkg::lvl_mask(l, NLEVEL);
        assign lvl_hit[l] = |(MASK & live);
    end

    always_comb begin
        sel = 1'b0;
        for (int l = 1; l <= NLEVEL; l++) begin
            if (pend_level_i == 4'(l)) sel = lvl_hit[l];
        end
    end

    assign in_range = (pend_level_i > cur_level_i) && (32'(pend_level_i) <= 32'(NLEVEL));
    assign hit_o    = in_range && sel;

endmodule

// File: rtl/irqd_vec.sv
module irqd_vec #(
    parameter int          RELOC_EN    = 1,
    parameter logic [31:0] DEF_VECBASE = 32'h4000_0000,
    parameter logic [31:0] HI_OFS0     = 32'h0000_0180,
    parameter logic [31:0] HI_STRIDE   = 32'h0000_0040,
    parameter logic [31:0] KERN_OFS    = 32'h0000_0300,
    parameter logic [31:0] USER_OFS    = 32'h0000_0340,
    parameter logic [31:0] DBL_OFS     = 32'h0000_03C0
) (
    input  irqd_pkg::route_e route_i,
    input  logic [3:0]       level_i,
    input  logic [31:0]      vecbase_i,
    output logic [31:0]      target_o
);
    logic [31:0] base;
    logic [31:0] ofs;

    if (RELOC_EN != 0) begin : g_reloc
        assign base = vecbase_i;
    end else begin : g_fixed
        assign base = DEF_VECBASE;
    end

    always_comb begin
        unique case (route_i)
            irqd_pkg::ROUTE_HIGH: ofs = HI_OFS0 + (({28'd0, level_i} - 32'd2) * HI_STRIDE);
            irqd_pkg::ROUTE_KERN: ofs = KERN_OFS;
            irqd_pkg::ROUTE_USER: ofs = USER_OFS;
            default:              ofs = DBL_OFS;
        endcase
    end

    assign target_o = base + ofs;

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
    parameter int          NLEVEL      = 6,
    parameter int          EXCM_BIT    = 4,
    parameter int          UM_BIT      = 5,
    parameter int          HAS_DEPC    = 1,
    parameter int          RELOC_EN    = 1,
    parameter logic [31:0] DEF_VECBASE = 32'h4000_0000,
    parameter logic [31:0] HI_OFS0     = 32'h0000_0180,
    parameter logic [31:0] HI_STRIDE   = 32'h0000_0040,
    parameter logic [31:0] KERN_OFS    = 32'h0000_0300,
    parameter logic [31:0] USER_OFS    = 32'h0000_0340,
    parameter logic [31:0] DBL_OFS     = 32'h0000_03C0,
    parameter logic [31:0] CAUSE_L1    = 32'd4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        eval_i,
    input  logic [3:0]  pend_level_i,
    input  logic [31:0] ps_i,
    input  logic [31:0] pc_i,
    input  logic [31:0] intset_i,
    input  logic [31:0] intenable_i,
    input  logic [31:0] vecbase_i,
    output logic        taken_o,
    output logic [31:0] pc_o,
    output logic [31:0] ps_o,
    output logic [31:0] save_pc_o,
    output logic [31:0] save_ps_o,
    output logic [3:0]  save_lvl_o,
    output logic [1:0]  route_o,
    output logic        epc_we_o,
    output logic        eps_we_o,
    output logic        depc_we_o,
    output logic        cause_we_o,
    output logic [31:0] cause_o
);
    import irqd_pkg::*;

    localparam int LW = 4;

    disp_s            st_d, st_q;
    logic             hit;
    route_e           route_sel;
    logic [31:0]      target;

    irqd_qual #(.NLEVEL(NLEVEL)) u_qual (
        .pend_level_i (pend_level_i),
        .cur_level_i  (ps_i[LW-1:0]),
        .intset_i     (intset_i),
        .intenable_i  (intenable_i),
        .hit_o        (hit)
    );

    always_comb begin
        if (pend_level_i > 4'd1)      route_sel = ROUTE_HIGH;
        else if (ps_i[EXCM_BIT])      route_sel = ROUTE_DBL;
        else if (ps_i[UM_BIT])        route_sel = ROUTE_USER;
        else                          route_sel = ROUTE_KERN;
    end

    irqd_vec #(
        .RELOC_EN    (RELOC_EN),
        .DEF_VECBASE (DEF_VECBASE),
        .HI_OFS0     (HI_OFS0),
        .HI_STRIDE   (HI_STRIDE),
        .KERN_OFS    (KERN_OFS),
        .USER_OFS    (USER_OFS),
        .DBL_OFS     (DBL_OFS)
    ) u_vec (
        .route_i   (route_sel),
        .level_i   (pend_level_i),
        .vecbase_i (vecbase_i),
        .target_o  (target)
    );

    always_comb begin
        st_d          = st_q;
        st_d.taken    = 1'b0;
        st_d.epc_we   = 1'b0;
        st_d.eps_we   = 1'b0;
        st_d.depc_we  = 1'b0;
        st_d.cause_we = 1'b0;
        if (eval_i && hit) begin
            st_d.taken = 1'b1;
            st_d.pc    = target;
            st_d.spc   = pc_i;
            st_d.sps   = ps_i;
            st_d.lvl   = pend_level_i;
            st_d.route = route_sel;
            if (route_sel == ROUTE_HIGH) begin
                st_d.ps           = {ps_i[31:LW], pend_level_i};
                st_d.ps[EXCM_BIT] = 1'b1;
                st_d.epc_we       = 1'b1;
                st_d.eps_we       = 1'b1;
            end else begin
                st_d.ps           = ps_i;
                st_d.ps[EXCM_BIT] = 1'b1;
                st_d.cause        = CAUSE_L1;
                st_d.cause_we     = 1'b1;
                st_d.lvl          = 4'd1;
                if (route_sel == ROUTE_DBL && HAS_DEPC != 0) st_d.depc_we = 1'b1;
                else                                         st_d.epc_we  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign taken_o    = st_q.taken;
    assign pc_o       = st_q.pc;
    assign ps_o       = st_q.ps;
    assign save_pc_o  = st_q.spc;
    assign save_ps_o  = st_q.sps;
    assign save_lvl_o = st_q.lvl;
    assign route_o    = st_q.route;
    assign epc_we_o   = st_q.epc_we;
    assign eps_we_o   = st_q.eps_we;
    assign depc_we_o  = st_q.depc_we;
    assign cause_we_o = st_q.cause_we;
    assign cause_o    = st_q.cause;

endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
    parameter int EXCM_BIT = 4,
    parameter int HAS_DEPC = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        eval_i,
    input logic        taken_o,
    input logic [31:0] pc_o,
    input logic [31:0] ps_o,
    input logic [3:0]  save_lvl_o,
    input logic [1:0]  route_o,
    input logic        epc_we_o,
    input logic        eps_we_o,
    input logic        depc_we_o,
    input logic        cause_we_o
);
    a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |-> ($stable(pc_o) && $stable(ps_o)));

    a_r9_taken_from_eval: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> $past(eval_i));

    a_r9_we_with_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (epc_we_o || eps_we_o || depc_we_o || cause_we_o) |-> taken_o);

    a_r2_high_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && route_o == 2'd0) |-> (epc_we_o && eps_we_o && !cause_we_o && !depc_we_o));

    a_r3_high_status: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && route_o == 2'd0) |-> (ps_o[3:0] == save_lvl_o && ps_o[EXCM_BIT]));

    a_r5_low_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && route_o != 2'd0) |-> (cause_we_o && ps_o[EXCM_BIT] && !eps_we_o && save_lvl_o == 4'd1));

    a_r6_double_target: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && route_o == 2'd3) |-> ((HAS_DEPC != 0) ? (depc_we_o && !epc_we_o) : (epc_we_o && !depc_we_o)));

    a_r7_single_pc_store: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && (route_o == 2'd1 || route_o == 2'd2)) |-> (epc_we_o && !depc_we_o));

endmodule

bind irq_dispatch irq_dispatch_chk #(.EXCM_BIT(EXCM_BIT), .HAS_DEPC(HAS_DEPC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_i     (eval_i),
    .taken_o    (taken_o),
    .pc_o       (pc_o),
    .ps_o       (ps_o),
    .save_lvl_o (save_lvl_o),
    .route_o    (route_o),
    .epc_we_o   (epc_we_o),
    .eps_we_o   (eps_we_o),
    .depc_we_o  (depc_we_o),
    .cause_we_o (cause_we_o)
);

// File: tb/sim_irq_dispatch.sv
module sim_irq_dispatch;

    typedef struct packed {
        logic        taken;
        logic [31:0] pc;
        logic [31:0] ps;
        logic [31:0] spc;
        logic [31:0] sps;
        logic [3:0]  lvl;
        logic [1:0]  route;
        logic [3:0]  wes;   // epc, eps, depc, cause
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eval_i = 1'b0;
    logic [3:0]  pend_level_i = '0;
    logic [31:0] ps_i = '0, pc_i = '0, intset_i = '0, intenable_i = '0;
    logic [31:0] vecbase_i = 32'h4000_0000;
    logic        taken_o;
    logic [31:0] pc_o, ps_o, save_pc_o, save_ps_o, cause_o;
    logic [3:0]  save_lvl_o;
    logic [1:0]  route_o;
    logic        epc_we_o, eps_we_o, depc_we_o, cause_we_o;

    int n_cmp = 0;
    int n_bad = 0;
    exp_t  exp_q[$];
    string tag_q[$];
    logic [31:0] last_pc = '0, last_ps = '0;

    always #5 clk = ~clk;

    irq_dispatch u0 (.*);

    function automatic logic [31:0] mask_of(input int lvl);
        logic [31:0] m = '0;
        for (int i = 0; i < 32; i++) if ((i % 6) + 1 == lvl) m[i] = 1'b1;
        return m;
    endfunction

    task automatic drive(input logic [3:0] lvl, input logic [31:0] ps, input logic [31:0] pc,
                         input logic [31:0] set, input logic [31:0] en,
                         input logic [31:0] vb, input string tag);
        exp_t e;
        logic hit;
        @(negedge clk);
        eval_i = 1'b1; pend_level_i = lvl; ps_i = ps; pc_i = pc;
        intset_i = set; intenable_i = en; vecbase_i = vb;
        hit = (lvl > ps[3:0]) && (lvl <= 4'd6) && ((mask_of(int'(lvl)) & set & en) != 0);
        e = '0;
        e.pc = last_pc; e.ps = last_ps;
        if (hit) begin
            e.taken = 1'b1; e.spc = pc; e.sps = ps;
            if (lvl > 1) begin
                e.pc = vb + 32'h180 + (32'(lvl) - 32'd2) * 32'h40;
                e.ps = {ps[31:4], lvl} | 32'h10;
                e.lvl = lvl; e.route = 2'd0; e.wes = 4'b1100;
            end else begin
                e.ps = ps | 32'h10; e.lvl = 4'd1;
                if (ps[4]) begin
                    e.pc = vb + 32'h3C0; e.route = 2'd3; e.wes = 4'b0011;
                end else if (ps[5]) begin
                    e.pc = vb + 32'h340; e.route = 2'd2; e.wes = 4'b1001;
                end else begin
                    e.pc = vb + 32'h300; e.route = 2'd1; e.wes = 4'b1001;
                end
            end
            last_pc = e.pc; last_ps = e.ps;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            eval_i = 1'b0;
        end
    endtask

    // Monitor: results appear one edge after the evaluate strobe.
    always @(posedge clk) begin
        if (rst_n && eval_i) begin
            exp_t e;
            string t;
            logic ok;
            #3;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            ok = (taken_o == e.taken) && (pc_o == e.pc) && (ps_o == e.ps) &&
                 ({epc_we_o, eps_we_o, depc_we_o, cause_we_o} == e.wes);
            if (e.taken)
                ok = ok && (save_pc_o == e.spc) && (save_ps_o == e.sps) &&
                     (save_lvl_o == e.lvl) && (route_o == e.route) &&
                     (!e.wes[0] || cause_o == 32'd4);
            if (!ok) begin
                n_bad++;
                $display("FAIL %s: got taken=%0b pc=%h ps=%h we=%b lvl=%0d route=%0d spc=%h sps=%h | exp taken=%0b pc=%h ps=%h we=%b lvl=%0d route=%0d spc=%h sps=%h",
                         t, taken_o, pc_o, ps_o, {epc_we_o, eps_we_o, depc_we_o, cause_we_o},
                         save_lvl_o, route_o, save_pc_o, save_ps_o,
                         e.taken, e.pc, e.ps, e.wes, e.lvl, e.route, e.spc, e.sps);
            end
        end
    end

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: got run still active, exp finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_cmp++;
        if (taken_o || pc_o != 0 || ps_o != 0 || epc_we_o || eps_we_o || depc_we_o || cause_we_o) begin
            n_bad++;
            $display("FAIL R10: got taken=%0b pc=%h ps=%h, exp all zero", taken_o, pc_o, ps_o);
        end

        // R2 R3 R4: level 3 from level 0
        drive(4'd3, 32'h0000_0000, 32'h1000_0010, 32'h4, 32'h4, 32'h4000_0000, "R2/R3/R4 level3");
        idle(1);
        // R1: enable missing
        drive(4'd3, 32'h0, 32'h1000_0020, 32'h4, 32'h0, 32'h4000_0000, "R1 not enabled");
        idle(1);
        // R1: equal level
        drive(4'd3, 32'h3, 32'h1000_0030, 32'h4, 32'h4, 32'h4000_0000, "R1 equal level");
        idle(1);
        // R1: above configured levels
        drive(4'd7, 32'h0, 32'h1000_0040, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h4000_0000, "R1 out of range");
        idle(1);
        // R1: level zero
        drive(4'd0, 32'h0, 32'h1000_0044, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h4000_0000, "R1 level zero");
        idle(1);
        // R1: lines of other levels only
        drive(4'd2, 32'h0, 32'h1000_0048, ~mask_of(2), 32'hFFFF_FFFF, 32'h4000_0000, "R1 wrong mask");
        idle(1);
        // R7 R5: user vector
        drive(4'd1, 32'h0000_0020, 32'h1000_0050, 32'h1, 32'h1, 32'h4000_0000, "R7/R5 user");
        idle(1);
        // R7 R5: kernel vector, upper status bits kept
        drive(4'd1, 32'hA500_0000, 32'h1000_0060, 32'h40, 32'h40, 32'h4000_0000, "R7/R5 kernel");
        idle(1);
        // R6 R5: double exception
        drive(4'd1, 32'h0000_0030, 32'h1000_0070, 32'h1, 32'h1, 32'h4000_0000, "R6/R5 double");
        idle(1);
        // R8: relocated base, level 6
        drive(4'd6, 32'h0000_0002, 32'h1000_0080, 32'h20, 32'h20, 32'h2000_0000, "R8/R4 reloc level6");
        idle(1);
        // R3: upper bits preserved, level 5 over 4
        drive(4'd5, 32'hC0DE_0024, 32'h1000_0090, 32'h10, 32'h10, 32'h4000_0000, "R3 keep bits");
        idle(1);
        // R9: back-to-back, taken then not taken
        drive(4'd2, 32'h0, 32'h1000_00A0, 32'h2, 32'h2, 32'h4000_0000, "R9 first");
        drive(4'd2, 32'h2, 32'h1000_00B0, 32'h2, 32'h2, 32'h4000_0000, "R9 second");
        drive(4'd4, 32'h1, 32'h1000_00C0, 32'h8, 32'h8, 32'h3000_0000, "R9 third");
        idle(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule